// File: doc/BRIEF.md
# DS3/E3 Transmit Frame Timing Generator

This block produces the bit-level frame timing for a serial DS3 or E3 transmit framer. It runs entirely in the transmit line-clock domain, keeps a bit-position counter that walks through one frame, and emits a one-cycle strobe while the final bit of each frame is handled. Downstream overhead insertion logic reads the bit index to find its overhead slots. Terminal equipment running raw payload uses the strobe as its cue to start shifting in the next frame.

A mode input picks the frame length: DS3 (nominal 44.736 MHz line clock) or E3 (nominal 34.368 MHz line clock). As frame master the counter runs free. As frame slave it restarts on every rising edge of a frame-rate reference. That reference is synchronous to the line clock, so its edge is found by comparing it with a registered copy, with no synchronizer. A reference edge that lands before the last bit cuts the running frame short without a strobe and raises a sticky realignment flag. The serial payload input is captured on the rising clock edge. External logic launches it on the falling edge.

Top module: `tx_frame_timer`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, bit_idx_o is 0 and eof_o, realign_o and pay_o are 0.
- R2: With e3_mode_i=0 the frame length L is 4760. Outside a restart, bit_idx_o rises by 1 each cycle and goes from L-1 to 0.
- R3: With e3_mode_i=1 the frame length L is 1536, with the same stepping and wrap as R2. e3_mode_i only changes while reset is held.
- R4: eof_o is 1 in exactly the cycles where bit_idx_o equals L-1, so it lasts one cycle per complete frame.
- R5: With slave_mode_i=1, a cycle in which frame_ref_i is 1 after being 0 in the previous cycle makes bit_idx_o equal 0 in the next cycle.
- R6: With slave_mode_i=0, frame_ref_i has no effect on bit_idx_o, eof_o or realign_o.
- R7: A restart under R5 that arrives when bit_idx_o is not L-1 gives no eof_o for the cut frame and sets realign_o from the next cycle.
- R8: realign_o stays 1 until a cycle with realign_clr_i=1 clears it for the next cycle. A truncating restart in the same cycle wins over the clear.
- R9: With slave_mode_i=1 and frame_ref_i held at 0, the counter runs free exactly as in R2 and R3.
- R10: pay_o equals the value of pay_i at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Transmit line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| e3_mode_i | input | 1 | 0 selects DS3 frame length, 1 selects E3 |
| slave_mode_i | input | 1 | 1 makes the counter follow frame_ref_i |
| frame_ref_i | input | 1 | Frame-rate reference, synchronous to clk_i |
| realign_clr_i | input | 1 | Clears the sticky realignment flag |
| pay_i | input | PAY_W | Serial payload input |
| bit_idx_o | output | IDX_W | Current bit position in the frame |
| eof_o | output | 1 | Last-bit-of-frame strobe |
| realign_o | output | 1 | Sticky flag: a frame was cut short by the reference |
| pay_o | output | PAY_W | Registered payload |

## Verification
A wrong count shows on bit_idx_o in the very next cycle, and it moves eof_o away from its expected cycle by up to a whole frame. Because of that, the bench compares the index, the strobe and the flag against a behavioural model on every clock rather than only at frame ends. A missed or false reference edge appears one cycle later as a bit_idx_o that fails to return to 0 or returns when it should not. A wrong flag update shows on realign_o within one cycle of the restart or the clear.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;
  localparam int unsigned DS3_BITS_DEF = 4760;
  localparam int unsigned E3_BITS_DEF  = 1536;

  typedef enum logic {MODE_DS3 = 1'b0, MODE_E3 = 1'b1} line_mode_e;

  function automatic int unsigned idx_width(input int unsigned a, input int unsigned b);
    return (a > b) ? $clog2(a) : $clog2(b);
  endfunction
endpackage

// File: rtl/tx_ref_edge.sv
module tx_ref_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_i,
  input  logic ref_i,
  output logic rise_o
);
  logic ref_q;

  // reference is already in the line-clock domain: one flop suffices
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_i;
  end

  assign rise_o = slave_i & ref_i & ~ref_q;
endmodule

// File: rtl/tx_bit_counter.sv
module tx_bit_counter #(
  parameter int unsigned DS3_BITS = tx_frame_pkg::DS3_BITS_DEF,
  parameter int unsigned E3_BITS  = tx_frame_pkg::E3_BITS_DEF,
  localparam int unsigned IDX_W   = tx_frame_pkg::idx_width(DS3_BITS, E3_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tx_frame_pkg::line_mode_e mode_i,
  input  logic             restart_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             eof_o,
  output logic             realign_o
);
  localparam logic [IDX_W-1:0] DS3_LAST = IDX_W'(DS3_BITS - 1);
  localparam logic [IDX_W-1:0] E3_LAST  = IDX_W'(E3_BITS - 1);

  logic [IDX_W-1:0] cnt_q, cnt_d, last_idx;
  logic             realign_q, realign_d, truncate;

  assign last_idx = (mode_i == tx_frame_pkg::MODE_E3) ? E3_LAST : DS3_LAST;
  assign eof_o    = (cnt_q == last_idx);
  assign truncate = restart_i & ~eof_o;

  always_comb begin
    if (restart_i)             cnt_d = '0;
    else if (cnt_q >= last_idx) cnt_d = '0;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    if (truncate)   realign_d = 1'b1;
    else if (clr_i) realign_d = 1'b0;
    else            realign_d = realign_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      realign_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      realign_q <= realign_d;
    end
  end

  assign idx_o     = cnt_q;
  assign realign_o = realign_q;

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && idx_o != last_idx) |=> idx_o == IDX_W'($past(idx_o) + 1'b1));
  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_o == last_idx) |=> idx_o == '0);
  p_eof_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> !eof_o);
  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> idx_o == '0);
  p_flag_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !eof_o) |=> realign_o);
  p_flag_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (realign_o && !clr_i) |=> realign_o);
endmodule

// File: rtl/tx_payload_reg.sv
module tx_payload_reg #(
  parameter int unsigned PAY_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PAY_W-1:0] d_i,
  output logic [PAY_W-1:0] q_o
);
  // data is launched on the falling edge upstream; capture on the rising edge
  for (genvar b = 0; b < PAY_W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o[b] <= 1'b0;
      else         q_o[b] <= d_i[b];
    end
  end

  p_capture_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> q_o == $past(d_i));
endmodule

// File: rtl/tx_frame_timer.sv
module tx_frame_timer #(
  parameter int unsigned DS3_BITS = tx_frame_pkg::DS3_BITS_DEF,
  parameter int unsigned E3_BITS  = tx_frame_pkg::E3_BITS_DEF,
  parameter int unsigned PAY_W    = 1,
  localparam int unsigned IDX_W   = tx_frame_pkg::idx_width(DS3_BITS, E3_BITS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             e3_mode_i,
  input  logic             slave_mode_i,
  input  logic             frame_ref_i,
  input  logic             realign_clr_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             eof_o,
  output logic             realign_o,
  output logic [PAY_W-1:0] pay_o
);
  logic ref_rise;
  tx_frame_pkg::line_mode_e mode;

  assign mode = e3_mode_i ? tx_frame_pkg::MODE_E3 : tx_frame_pkg::MODE_DS3;

  tx_ref_edge u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .slave_i (slave_mode_i),
    .ref_i   (frame_ref_i),
    .rise_o  (ref_rise)
  );

  tx_bit_counter #(.DS3_BITS(DS3_BITS), .E3_BITS(E3_BITS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .restart_i (ref_rise),
    .clr_i     (realign_clr_i),
    .idx_o     (bit_idx_o),
    .eof_o     (eof_o),
    .realign_o (realign_o)
  );

  tx_payload_reg #(.PAY_W(PAY_W)) u_pay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pay_i),
    .q_o    (pay_o)
  );

  p_master_free_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !eof_o) |=> bit_idx_o == IDX_W'($past(bit_idx_o) + 1'b1));
  p_flag_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slave_mode_i && !realign_o) |=> !realign_o || realign_o == 1'b0);
endmodule

// File: tb/tx_frame_timer_tb.sv
module tx_frame_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DS3_L = 4760;
  localparam int E3_L  = 1536;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic e3_mode = 1'b0, slave = 1'b0, fref = 1'b0, clr = 1'b0;
  logic [0:0] pay_in = 1'b0;
  logic [12:0] bit_idx;
  logic eof, realign;
  logic [0:0] pay_out;

  int n_cmp = 0, n_bad = 0;
  int m_idx = 0, m_len = DS3_L;
  bit m_refq = 0, m_realign = 0, m_pay = 0;
  string req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tx_frame_timer u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .e3_mode_i(e3_mode), .slave_mode_i(slave),
    .frame_ref_i(fref), .realign_clr_i(clr), .pay_i(pay_in),
    .bit_idx_o(bit_idx), .eof_o(eof), .realign_o(realign), .pay_o(pay_out)
  );

  task automatic check_one(string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      if (n_bad < 20) $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    check_one("bit_idx", int'(bit_idx), m_idx);
    check_one("eof(R4)", int'(eof), (m_idx == m_len - 1) ? 1 : 0);
    check_one("realign(R7,R8)", int'(realign), int'(m_realign));
    check_one("payload(R10)", int'(pay_out), int'(m_pay));
  endtask

  // one clock: drive inputs, advance model, compare after the edge
  task automatic step(bit r, bit c, bit d);
    bit rise;
    fref = r; clr = c; pay_in = d;
    rise = slave && r && !m_refq;
    if (rise && m_idx != m_len - 1) m_realign = 1;
    else if (c) m_realign = 0;
    if (rise || m_idx == m_len - 1) m_idx = 0;
    else m_idx = m_idx + 1;
    m_refq = r; m_pay = d;
    @(negedge clk);
    compare();
  endtask

  task automatic do_reset(bit e3, bit sl);
    req = "R1";
    rst_ni = 1'b0; fref = 0; clr = 0; pay_in = 1'b1;
    e3_mode = e3; slave = sl;
    m_len = e3 ? E3_L : DS3_L;
    m_idx = 0; m_refq = 0; m_realign = 0; m_pay = 0;
    repeat (3) @(negedge clk);
    compare();
    rst_ni = 1'b1;
    pay_in = 1'b0;
    step(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset(0, 0);
    req = "R2";
    for (int i = 0; i < DS3_L + 200; i++) step(0, 0, 1'($urandom));

    do_reset(1, 0);
    req = "R3";
    for (int i = 0; i < 2 * E3_L + 50; i++) step(0, 0, 1'($urandom));

    req = "R6";
    for (int i = 0; i < 700; i++) step(1'(i % 37 < 5), 0, 1'($urandom));

    do_reset(1, 1);
    req = "R9";
    for (int i = 0; i < E3_L + 40; i++) step(0, 0, 1'($urandom));

    req = "R5";
    for (int i = 0; i < 3 * E3_L; i++) step(m_idx == E3_L - 1, 0, 1'($urandom));

    req = "R7";
    while (m_idx != 300) step(0, 0, 0);
    step(1, 0, 1);
    for (int i = 0; i < 40; i++) step(1, 0, 1'($urandom));
    for (int i = 0; i < E3_L + 10; i++) step(0, 0, 1'($urandom));

    req = "R8";
    step(0, 1, 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    while (m_idx != 10) step(0, 0, 0);
    step(1, 1, 0);
    step(0, 0, 0);
    step(0, 1, 0);
    step(0, 0, 0);
    step(0, 0, 0);
    step(1, 0, 0);
    step(0, 1, 1);

    do_reset(0, 1);
    req = "R5";
    for (int i = 0; i < 100; i++) step(0, 0, 1'($urandom));
    for (int i = 0; i < 2 * DS3_L; i++) step(m_idx == DS3_L - 1 || m_idx == 2000, 0, 1'($urandom));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule